// File: doc/BRIEF.md
# Down-Counting Event Timer

This block is a 32-bit down-counting timer for a system processor that has no timer of its own. It sits on a simple CSR bus: byte addresses, 32-bit word-aligned registers, a single write strobe, and a read path with one cycle of latency. Software gives a start value and a period value, then sets a run bit. While running, the count drops by one on each clock. When it reaches zero, it flags an event.

A non-zero period makes the timer periodic: the count restarts from the period one cycle after it reaches zero. A period of zero makes it one-shot: the count holds at zero, so the event fires only once. To retarget the timer, software clears the run bit, writes a new start value and sets the run bit again.

The live count can change while software is reading it. To get a coherent copy, software writes the capture register and then reads the held copy. The zero event has three views: a live level, a sticky flag cleared by writing 1, and a mask bit. The flag and the mask together drive a registered level interrupt.

Top module: `dtimer_top`

## Requirements
- R1: After synchronous reset, the start, period, run, mask and flag registers, the count and the captured copy are all zero, and `irq_o` is low.
- R2: Registers decode on word index `csr_addr[4:2]`: 0 start, 1 period, 2 run (bit 0), 3 capture request, 4 captured count, 5 live zero level (bit 0), 6 event flag (bit 0), 7 mask (bit 0). An access whose `csr_addr[1:0]` is non-zero writes nothing.
- R3: While the run bit is 0, the count takes the start register's value on every clock. After the run bit is set, counting therefore begins at the last start value written.
- R4: While the run bit is 1 and the count is non-zero, the count decreases by exactly one per clock.
- R5: The event flag is set on the clock edge where a running count moves from 1 to 0. A run that begins with a start value of 0 raises no event.
- R6: With a non-zero period and the count at zero while running, the next clock loads the period. Events then repeat every period+1 cycles.
- R7: With a period of zero, the count stays at zero after it gets there, and the flag is set only once.
- R8: A write of any data to the capture request copies the count on that clock edge into the captured register. Reading index 4 returns that copy.
- R9: Bit 0 of index 5 reads 1 exactly when the count is zero. Writes to index 5 change nothing.
- R10: Writing 1 to bit 0 of the flag clears it, and writing 0 leaves it unchanged. If a new event and a clear arrive on the same edge, the flag ends up set.
- R11: `irq_o` is high exactly when the flag and the mask bit are both 1. It follows either of them on the same edge.
- R12: `csr_rdata` is registered. It shows the register chosen by `csr_addr` in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_addr | input | 5 | Byte address of the access |
| csr_we | input | 1 | Write strobe |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Level interrupt: flag AND mask |

## Verification
On every cycle the bound checker enforces the count's next-state rules: following the start value while stopped, decrementing by one, and reloading the period at zero. It also checks that a running 1-to-0 step raises the flag and that the interrupt equals flag AND mask. Other behaviours need whole scenarios from the bench: the captured value after a chosen delay, one-shot holding with no repeat event, periodic re-firing after a clear, the tie between a clear and a new event, ignored writes to the level register and to misaligned addresses, and the one-cycle read latency.

// File: rtl/dtimer_pkg.sv
package dtimer_pkg;

  // Word indexes of the register slots (byte offset = index * 4).
  localparam int unsigned IDX_START     = 0;
  localparam int unsigned IDX_PERIOD    = 1;
  localparam int unsigned IDX_RUN       = 2;
  localparam int unsigned IDX_SNAP_REQ  = 3;
  localparam int unsigned IDX_SNAP_DATA = 4;
  localparam int unsigned IDX_EVT_LEVEL = 5;
  localparam int unsigned IDX_EVT_FLAG  = 6;
  localparam int unsigned IDX_EVT_MASK  = 7;

  // Single-cycle write strobes produced by the CSR decoder.
  typedef struct packed {
    logic snap_we;
    logic flag_we;
    logic mask_we;
  } wr_strobe_t;

endpackage

// File: rtl/dtimer_csr.sv
module dtimer_csr
  import dtimer_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] snap_val,
  input  logic              level,
  input  logic              pend,
  input  logic              mask,
  output logic [DATA_W-1:0] start_q,
  output logic [DATA_W-1:0] period_q,
  output logic              run_q,
  output wr_strobe_t        strb,
  output logic [DATA_W-1:0] rdata_q
);

  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             aligned;
  logic             wr_ok;

  assign idx     = addr[ADDR_W-1:2];
  assign aligned = (addr[1:0] == 2'b00);
  assign wr_ok   = we && aligned;

  // Strobes for registers that live in other sub-blocks.
  always_comb begin
    strb.snap_we = wr_ok && (idx == IDX_W'(IDX_SNAP_REQ));
    strb.flag_we = wr_ok && (idx == IDX_W'(IDX_EVT_FLAG));
    strb.mask_we = wr_ok && (idx == IDX_W'(IDX_EVT_MASK));
  end

  // Locally held configuration registers.
  always_ff @(posedge clk) begin
    if (rst) begin
      start_q  <= '0;
      period_q <= '0;
      run_q    <= 1'b0;
    end else if (wr_ok) begin
      if (idx == IDX_W'(IDX_START))  start_q  <= wdata;
      if (idx == IDX_W'(IDX_PERIOD)) period_q <= wdata;
      if (idx == IDX_W'(IDX_RUN))    run_q    <= wdata[0];
    end
  end

  // Registered read multiplexer.
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    case (idx)
      IDX_W'(IDX_START):     rd_mux = start_q;
      IDX_W'(IDX_PERIOD):    rd_mux = period_q;
      IDX_W'(IDX_RUN):       rd_mux[0] = run_q;
      IDX_W'(IDX_SNAP_DATA): rd_mux = snap_val;
      IDX_W'(IDX_EVT_LEVEL): rd_mux[0] = level;
      IDX_W'(IDX_EVT_FLAG):  rd_mux[0] = pend;
      IDX_W'(IDX_EVT_MASK):  rd_mux[0] = mask;
      default:               rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_mux;
  end

endmodule

// File: rtl/dtimer_core.sv
module dtimer_core #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CNT_W-1:0] start_val,
  input  logic [CNT_W-1:0] period_val,
  input  logic             snap_we,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] snap_q,
  output logic             at_zero,
  output logic             zero_hit
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assign at_zero  = (cnt_q == '0);
  // A running count about to step from 1 to 0 marks the event edge.
  assign zero_hit = run && (cnt_q == ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (!run) begin
      cnt_q <= start_val;
    end else if (at_zero) begin
      // A zero period reloads zero, so one-shot mode simply holds.
      cnt_q <= period_val;
    end else begin
      cnt_q <= cnt_q - ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          snap_q <= '0;
    else if (snap_we) snap_q <= cnt_q;
  end

endmodule

// File: rtl/dtimer_evt.sv
module dtimer_evt (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr_we,
  input  logic clr_bit,
  input  logic mask_we,
  input  logic mask_bit,
  output logic pend_q,
  output logic mask_q,
  output logic irq_q
);

  logic pend_d;
  logic mask_d;

  // A new event outranks a clear arriving on the same edge.
  assign pend_d = set || (pend_q && !(clr_we && clr_bit));
  assign mask_d = mask_we ? mask_bit : mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      mask_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      mask_q <= mask_d;
      irq_q  <= pend_d && mask_d;
    end
  end

endmodule

// File: rtl/dtimer_top.sv
module dtimer_top
  import dtimer_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic              csr_we,
  input  logic [DATA_W-1:0] csr_wdata,
  output logic [DATA_W-1:0] csr_rdata,
  output logic              irq_o
);

  logic [DATA_W-1:0] start_q;
  logic [DATA_W-1:0] period_q;
  logic              run_q;
  wr_strobe_t        strb;
  logic [DATA_W-1:0] cnt_q;
  logic [DATA_W-1:0] snap_q;
  logic              at_zero;
  logic              zero_hit;
  logic              pend_q;
  logic              mask_q;

  dtimer_csr #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) csr_i (
    .clk      (clk),
    .rst      (rst),
    .addr     (csr_addr),
    .we       (csr_we),
    .wdata    (csr_wdata),
    .snap_val (snap_q),
    .level    (at_zero),
    .pend     (pend_q),
    .mask     (mask_q),
    .start_q  (start_q),
    .period_q (period_q),
    .run_q    (run_q),
    .strb     (strb),
    .rdata_q  (csr_rdata)
  );

  dtimer_core #(
    .CNT_W (DATA_W)
  ) core_i (
    .clk        (clk),
    .rst        (rst),
    .run        (run_q),
    .start_val  (start_q),
    .period_val (period_q),
    .snap_we    (strb.snap_we),
    .cnt_q      (cnt_q),
    .snap_q     (snap_q),
    .at_zero    (at_zero),
    .zero_hit   (zero_hit)
  );

  dtimer_evt evt_i (
    .clk      (clk),
    .rst      (rst),
    .set      (zero_hit),
    .clr_we   (strb.flag_we),
    .clr_bit  (csr_wdata[0]),
    .mask_we  (strb.mask_we),
    .mask_bit (csr_wdata[0]),
    .pend_q   (pend_q),
    .mask_q   (mask_q),
    .irq_q    (irq_o)
  );

endmodule

// File: rtl/dtimer_chk.sv
module dtimer_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              run,
  input logic [DATA_W-1:0] start_val,
  input logic [DATA_W-1:0] period_val,
  input logic [DATA_W-1:0] cnt,
  input logic              pend,
  input logic              mask,
  input logic              irq
);

  // R3: a stopped timer follows the start register
  p_follow_start_r3: assert property (@(posedge clk) disable iff (rst)
    !run |=> cnt == $past(start_val));

  // R4: one step down per clock while running above zero
  p_decrement_r4: assert property (@(posedge clk) disable iff (rst)
    (run && cnt != '0) |=> cnt == $past(cnt) - DATA_W'(1));

  // R5: the 1-to-0 step raises the flag
  p_event_set_r5: assert property (@(posedge clk) disable iff (rst)
    (run && cnt == DATA_W'(1)) |=> pend);

  // R6 and R7: at zero the period is taken (zero keeps it at zero)
  p_reload_r6: assert property (@(posedge clk) disable iff (rst)
    (run && cnt == '0) |=> cnt == $past(period_val));

  // R11: interrupt level equals flag AND mask
  p_irq_level_r11: assert property (@(posedge clk) disable iff (rst)
    irq == (pend && mask));

endmodule

bind dtimer_top dtimer_chk #(.DATA_W(DATA_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .run        (run_q),
  .start_val  (start_q),
  .period_val (period_q),
  .cnt        (cnt_q),
  .pend       (pend_q),
  .mask       (mask_q),
  .irq        (irq_o)
);

// File: tb/dtimer_top_tb_top.sv
`timescale 1ns/1ps
module dtimer_top_tb_top;
  import dtimer_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  logic [31:0] v;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  dtimer_top dut_i (
    .clk       (clk),
    .rst       (rst),
    .csr_addr  (addr),
    .csr_we    (we),
    .csr_wdata (wdata),
    .csr_rdata (rdata),
    .irq_o     (irq)
  );

  // Table: start value, cycles waited after run, expected capture (period 0).
  localparam int NV = 6;
  localparam int VL [NV] = '{20, 100, 7, 5, 1000, 64};
  localparam int VN [NV] = '{3,  50,  7, 12, 1,    63};
  localparam int VE [NV] = '{17, 50,  0, 0,  999,  1};

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_raw(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; we = 1'b1; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic wr(int idx, logic [31:0] d);
    wr_raw(5'(idx * 4), d);
  endtask

  task automatic rd(int idx, output logic [31:0] d);
    @(negedge clk);
    addr = 5'(idx * 4);
    @(negedge clk);
    d = rdata;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 irq", {31'd0, irq}, 32'd0);
    rd(IDX_START, v);     chk("R1 start", v, 32'd0);
    rd(IDX_RUN, v);       chk("R1 run", v, 32'd0);
    rd(IDX_SNAP_DATA, v); chk("R1 capture", v, 32'd0);
    rd(IDX_EVT_FLAG, v);  chk("R1 flag", v, 32'd0);
    rd(IDX_EVT_LEVEL, v); chk("R9 level at reset count", v, 32'd1);

    // R2 decode and misaligned writes
    wr(IDX_START, 32'h1234_5678);
    wr(IDX_PERIOD, 32'hA5A5_0001);
    wr(IDX_EVT_MASK, 32'd1);
    rd(IDX_START, v);     chk("R2 start", v, 32'h1234_5678);
    rd(IDX_PERIOD, v);    chk("R2 period", v, 32'hA5A5_0001);
    rd(IDX_EVT_MASK, v);  chk("R2 mask", v, 32'd1);
    wr_raw(5'h01, 32'h0000_DEAD);
    rd(IDX_START, v);     chk("R2 misaligned ignored", v, 32'h1234_5678);

    // R12 one-cycle read latency
    @(negedge clk); addr = 5'(IDX_PERIOD * 4);
    #1 chk("R12 old data held", rdata, 32'h1234_5678);
    @(negedge clk);
    chk("R12 new data", rdata, 32'hA5A5_0001);
    wr(IDX_EVT_MASK, 32'd0);

    // R3 stopped count follows start
    wr(IDX_START, 32'd9);
    wr(IDX_SNAP_REQ, 32'hFFFF_FFFF);
    rd(IDX_SNAP_DATA, v); chk("R3 stopped count = start", v, 32'd9);

    // Table walk: R4, R7, R8 (one-shot)
    wr(IDX_PERIOD, 32'd0);
    for (int i = 0; i < NV; i++) begin
      wr(IDX_RUN, 32'd0);
      wr(IDX_START, VL[i]);
      wr(IDX_RUN, 32'd1);
      repeat (VN[i]) @(posedge clk);
      wr(IDX_SNAP_REQ, 32'd0);
      rd(IDX_SNAP_DATA, v);
      chk($sformatf("R4/R8 vector %0d", i), v, VE[i]);
      wr(IDX_EVT_FLAG, 32'd1);
    end

    // R5 / R11 interrupt edge timing
    wr(IDX_RUN, 32'd0);
    wr(IDX_EVT_FLAG, 32'd1);
    wr(IDX_EVT_MASK, 32'd1);
    wr(IDX_START, 32'd5);
    wr(IDX_RUN, 32'd1);
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R5 no irq before zero", {31'd0, irq}, 32'd0);
    @(posedge clk);
    @(negedge clk);
    chk("R5/R11 irq at zero", {31'd0, irq}, 32'd1);
    rd(IDX_EVT_FLAG, v);  chk("R5 flag set", v, 32'd1);
    rd(IDX_EVT_LEVEL, v); chk("R9 level at zero", v, 32'd1);

    // R7 / R10 one-shot does not refire after clear
    wr(IDX_EVT_FLAG, 32'd1);
    repeat (20) @(posedge clk);
    rd(IDX_EVT_FLAG, v);  chk("R7 single event", v, 32'd0);
    chk("R10 irq after clear", {31'd0, irq}, 32'd0);

    // R11 mask gating, R10 write-0 has no effect
    wr(IDX_RUN, 32'd0);
    wr(IDX_EVT_MASK, 32'd0);
    wr(IDX_START, 32'd3);
    wr(IDX_RUN, 32'd1);
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk("R11 masked irq low", {31'd0, irq}, 32'd0);
    wr(IDX_EVT_MASK, 32'd1);
    chk("R11 irq on unmask", {31'd0, irq}, 32'd1);
    wr(IDX_EVT_FLAG, 32'd0);
    rd(IDX_EVT_FLAG, v);  chk("R10 write 0 keeps flag", v, 32'd1);
    wr(IDX_EVT_FLAG, 32'd1);
    chk("R10/R11 clear drops irq", {31'd0, irq}, 32'd0);

    // R9 writes to level ignored
    wr(IDX_RUN, 32'd0);
    wr(IDX_START, 32'd50);
    wr(IDX_RUN, 32'd1);
    wr(IDX_EVT_LEVEL, 32'd1);
    rd(IDX_EVT_LEVEL, v); chk("R9 level write ignored", v, 32'd0);

    // R6 periodic reload and refire
    wr(IDX_RUN, 32'd0);
    wr(IDX_PERIOD, 32'd4);
    wr(IDX_START, 32'd4);
    wr(IDX_RUN, 32'd1);
    repeat (6) @(posedge clk);
    wr(IDX_SNAP_REQ, 32'd0);
    rd(IDX_SNAP_DATA, v); chk("R6 count after wrap", v, 32'd3);
    wr(IDX_EVT_FLAG, 32'd1);
    repeat (12) @(posedge clk);
    rd(IDX_EVT_FLAG, v);  chk("R6 periodic refire", v, 32'd1);

    // R5 zero start raises no event
    wr(IDX_RUN, 32'd0);
    wr(IDX_PERIOD, 32'd0);
    wr(IDX_START, 32'd0);
    wr(IDX_EVT_FLAG, 32'd1);
    wr(IDX_RUN, 32'd1);
    repeat (10) @(posedge clk);
    rd(IDX_EVT_FLAG, v);  chk("R5 zero start no event", v, 32'd0);

    // R10 event beats a simultaneous clear
    wr(IDX_RUN, 32'd0);
    wr(IDX_START, 32'd2);
    wr(IDX_RUN, 32'd1);
    repeat (10) @(posedge clk);
    wr(IDX_RUN, 32'd0);
    wr(IDX_RUN, 32'd1);
    wr(IDX_EVT_FLAG, 32'd1);
    rd(IDX_EVT_FLAG, v);  chk("R10 event wins over clear", v, 32'd1);

    finish_run();
  end

endmodule